// File: doc/BRIEF.md
# Bit-Plane Watermark Embedder

This block hides a binary watermark string inside a stream of 8-bit grayscale pixels that arrive one per handshake, already flattened into a 1-D sequence. Each pixel's upper five bits pass through a six-input selection function. The sixth input is one bit of a private key register that rotates once per accepted pixel. When the function fires, the next watermark bit replaces bit 2 of the pixel, which is its third bit plane. When it does not fire, the pixel passes through untouched.

Before a frame, the watermark and the key are loaded in parallel with a load strobe. The block counts the embeddings. Once the whole watermark has been written, it raises a done flag, clears the watermark register and lets every later pixel through unchanged. Bit 2 never takes part in the selection, so a decoder working on the stego image makes the same choices as the embedder.

Top module: `wm_embed`

## Requirements
- R1: While reset is held, and in the first cycle after it, out_valid is 0, embed_count is 0 and done is 1. In the first cycle after reset, in_ready is 1.
- R2: A pixel qualifies for embedding only when its bits 7 and 6 are both 1 and at least one of bits 5, 4 and 3 is 1. The key bit does not change this outcome.
- R3: A qualifying pixel accepted while done is 0 leaves the block with bit 2 replaced by the current watermark bit. Bits 7..3 and 1..0 are unchanged.
- R4: A non-qualifying pixel leaves the block exactly as it entered. It consumes no watermark bit and does not change embed_count.
- R5: Watermark bits are embedded in ascending order of load_mark, starting with bit 0.
- R6: embed_count increases by one on each embedding. When it reaches WM_LEN (16 by default), done becomes 1, embed_count holds, and every later pixel passes unaltered.
- R7: A cycle with load_en high installs load_mark and load_key, sets embed_count to 0 and done to 0. in_ready is 0 during that cycle.
- R8: An accepted pixel appears on out_pixel with out_valid high in the following cycle. While out_valid is high and out_ready is low, out_pixel and out_valid hold and in_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Strobe that loads the watermark and the key |
| load_mark | input | WM_LEN | Watermark bits; bit 0 is embedded first |
| load_key | input | KEY_W | Private key seed; bit 0 is the first key bit used |
| in_valid | input | 1 | Input pixel is valid |
| in_ready | output | 1 | The block can accept an input pixel |
| in_pixel | input | 8 | Input grayscale pixel |
| out_valid | output | 1 | Output pixel is valid |
| out_ready | input | 1 | The consumer takes the output pixel |
| out_pixel | output | 8 | Output pixel, either watermarked or unaltered |
| embed_count | output | CNT_W | Number of watermark bits embedded since the last load |
| done | output | 1 | The whole watermark has been embedded, or nothing is loaded |

## Verification
The assertions assume that the load strobe and the pixel traffic do not overlap in a way that matters. in_ready falls during a load, so no pixel can be accepted in that cycle. They also assume that the consumer may stall out_ready for any length of time, and that in_pixel only counts when the handshake completes. The stimulus raises load_en only while the output stage is empty. It changes in_pixel and in_valid only away from the clock edge. Once, it holds out_ready low for several cycles to exercise the stall case.

// File: rtl/wm_pkg.sv
// Shared types and helpers for the bit-plane watermark embedder.
// Assumes 8-bit grayscale pixels; the embedding plane is fixed at bit 2.
package wm_pkg;
    localparam int PIX_W = 8;
    localparam int PLANE = 2;
    localparam int SEL_LO = PLANE + 1;

    typedef logic [PIX_W-1:0] pix_t;

    // Write one bit into the embedding plane, keeping every other bit.
    function automatic pix_t put_plane(input pix_t px, input logic b);
        pix_t r;
        r = px;
        r[PLANE] = b;
        return r;
    endfunction
endpackage

// File: rtl/wm_select.sv
// Six-input pixel selection function.
// Inputs u..y are pixel bits 7..3 and z is the current key bit.
// Written as a sum of products; the z literal appears in both polarities.
module wm_select (
    input  logic u,
    input  logic v,
    input  logic w,
    input  logic x,
    input  logic y,
    input  logic z,
    output logic fire
);
    // Evaluate the selection sum of products.
    always_comb begin
        fire = (u & v & ~w & x & ~y)
             | (u & v & w & x & ~y)
             | (u & v & w & ~x & ~y)
             | (u & v & y & z)
             | (u & v & y & ~z);
    end
endmodule

// File: rtl/wm_mark_bank.sv
// Watermark and key storage with the embedding counter.
// Assumes step pulses once per accepted pixel and load never coincides
// with step (the top module blocks input during a load).
module wm_mark_bank #(
    parameter int WM_LEN = 16,
    parameter int KEY_W  = 8,
    parameter int CNT_W  = $clog2(WM_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WM_LEN-1:0] load_mark,
    input  logic [KEY_W-1:0]  load_key,
    input  logic              step,
    input  logic              fire,
    output logic              cur_bit,
    output logic              key_bit,
    output logic [CNT_W-1:0]  count,
    output logic              done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WM_LEN);

    logic [WM_LEN-1:0] mark_q;
    logic [KEY_W-1:0]  key_q;
    logic              embed;

    assign embed   = step && fire && !done;
    assign cur_bit = mark_q[0];
    assign key_bit = key_q[0];

    // Watermark shift register: advances only when a bit is embedded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_q <= '0;
        end else if (load) begin
            mark_q <= load_mark;
        end else if (embed) begin
            if (count + 1'b1 == LAST) mark_q <= '0;
            else                      mark_q <= mark_q >> 1;
        end
    end

    // Key register: rotates once per accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)     key_q <= '0;
        else if (load)  key_q <= load_key;
        else if (step)  key_q <= {key_q[0], key_q[KEY_W-1:1]};
    end

    // Embedding counter and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            done  <= 1'b1;
        end else if (load) begin
            count <= '0;
            done  <= 1'b0;
        end else if (embed) begin
            count <= count + 1'b1;
            if (count + 1'b1 == LAST) done <= 1'b1;
        end
    end

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST);

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (count == $past(count)) || (count == $past(count) + 1'b1));

    assert_done_at_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) && !$past(load) |-> count == LAST);

    assert_load_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == '0 && !done);
endmodule

// File: rtl/wm_embed.sv
// Bit-plane watermark embedder top.
// Takes one pixel per valid/ready handshake and registers the result with
// one cycle of latency. Assumes load_en is raised between frames.
module wm_embed #(
    parameter int WM_LEN = 16,
    parameter int KEY_W  = 8,
    parameter int CNT_W  = $clog2(WM_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [WM_LEN-1:0] load_mark,
    input  logic [KEY_W-1:0]  load_key,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_pixel,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_pixel,
    output logic [CNT_W-1:0]  embed_count,
    output logic              done
);
    import wm_pkg::*;

    logic accept;
    logic fire;
    logic cur_bit;
    logic key_bit;
    pix_t next_px;

    assign in_ready = rst_n && !load_en && (!out_valid || out_ready);
    assign accept   = in_valid && in_ready;

    wm_select u_sel (
        .u    (in_pixel[7]),
        .v    (in_pixel[6]),
        .w    (in_pixel[5]),
        .x    (in_pixel[4]),
        .y    (in_pixel[SEL_LO]),
        .z    (key_bit),
        .fire (fire)
    );

    wm_mark_bank #(
        .WM_LEN (WM_LEN),
        .KEY_W  (KEY_W),
        .CNT_W  (CNT_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_en),
        .load_mark (load_mark),
        .load_key  (load_key),
        .step      (accept),
        .fire      (fire),
        .cur_bit   (cur_bit),
        .key_bit   (key_bit),
        .count     (embed_count),
        .done      (done)
    );

    // Choose between the embedded pixel and the unaltered pixel.
    always_comb begin
        next_px = (fire && !done) ? put_plane(in_pixel, cur_bit) : in_pixel;
    end

    // Output register with valid/ready hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pixel <= '0;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_pixel <= next_px;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pixel));

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

    assert_only_plane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (out_pixel & 8'hFB) == ($past(in_pixel) & 8'hFB));

    assert_pass_unsel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !(in_pixel[7] && in_pixel[6] && (|in_pixel[5:3]))
        |=> out_pixel == $past(in_pixel));
endmodule

// File: tb/sim_wm_embed.sv
module sim_wm_embed;
    localparam int WM_LEN = 16;
    localparam int KEY_W  = 8;
    localparam int CNT_W  = $clog2(WM_LEN + 1);

    logic              clk = 1'b0;
    logic              rst_n;
    logic              load_en;
    logic [WM_LEN-1:0] load_mark;
    logic [KEY_W-1:0]  load_key;
    logic              in_valid;
    logic              in_ready;
    logic [7:0]        in_pixel;
    logic              out_valid;
    logic              out_ready;
    logic [7:0]        out_pixel;
    logic [CNT_W-1:0]  embed_count;
    logic              done;

    int n_chk = 0;
    int n_bad = 0;

    logic [WM_LEN-1:0] m_mark;
    int                m_idx;
    logic              m_done;

    always #4 clk = ~clk;

    wm_embed #(.WM_LEN(WM_LEN), .KEY_W(KEY_W)) u0 (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_mark(load_mark),
        .load_key(load_key), .in_valid(in_valid), .in_ready(in_ready),
        .in_pixel(in_pixel), .out_valid(out_valid), .out_ready(out_ready),
        .out_pixel(out_pixel), .embed_count(embed_count), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic qual(input logic [7:0] p);
        return p[7] & p[6] & (p[5] | p[4] | p[3]);
    endfunction

    // Send one pixel and check the output and the counter.
    task automatic send_px(input logic [7:0] p, input string req);
        logic [7:0] exp;
        exp = p;
        if (qual(p) && !m_done) begin
            exp[2] = m_mark[m_idx];
            m_idx++;
            if (m_idx == WM_LEN) m_done = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_pixel = p;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " out_valid"}, out_valid, 1);
        check({req, " pixel"}, out_pixel, exp);
        check({req, " count"}, embed_count, m_idx);
        check({req, " done"}, done, m_done);
    endtask

    task automatic do_load(input logic [WM_LEN-1:0] m, input logic [KEY_W-1:0] k);
        @(negedge clk);
        load_en = 1'b1; load_mark = m; load_key = k;
        #1 check("R7 in_ready low during load", in_ready, 0);
        @(negedge clk);
        load_en = 1'b0;
        m_mark = m; m_idx = 0; m_done = 1'b0;
        check("R7 count cleared", embed_count, 0);
        check("R7 done cleared", done, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 out_valid", out_valid, 0);
        check("R1 count", embed_count, 0);
        check("R1 done", done, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 in_ready", in_ready, 1);
        m_done = 1'b1; m_idx = 0; m_mark = '0;
        send_px(8'hFF, "R6 unloaded passes");
    endtask

    task automatic t_unselected();
        send_px(8'h00, "R4 zero");
        send_px(8'hBF, "R2 bit6 clear");
        send_px(8'h7F, "R2 bit7 clear");
        send_px(8'hC0, "R2 low group clear");
        send_px(8'hC7, "R4 bit2 kept");
    endtask

    task automatic t_selected();
        send_px(8'hC8, "R2 bit3 only");
        send_px(8'hD0, "R3 bit4 only");
        send_px(8'hE0, "R3 bit5 only");
        send_px(8'hFF, "R5 all ones");
        send_px(8'hFB, "R5 plane clear");
        send_px(8'hCC, "R3 mixed");
    endtask

    task automatic t_finish();
        for (int i = 0; i < 12; i++) send_px(8'hD9 ^ 8'(i), "R6 fill");
        check("R6 done after fill", done, 1);
        check("R6 count at len", embed_count, WM_LEN);
        send_px(8'hF0, "R6 after done");
        send_px(8'hFF, "R6 after done 2");
    endtask

    task automatic t_stall();
        logic [7:0] exp;
        exp = 8'hE3;
        exp[2] = m_mark[m_idx];
        m_idx++;
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_pixel = 8'hE3;
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R8 held valid", out_valid, 1);
            check("R8 held pixel", out_pixel, exp);
            check("R8 in_ready low", in_ready, 0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        check("R8 drained", out_valid, 0);
        check("R8 count", embed_count, m_idx);
    endtask

    initial begin
        load_en = 0; load_mark = '0; load_key = '0;
        in_valid = 0; in_pixel = '0; out_ready = 1;
        t_reset();
        do_load(16'hA5C3, 8'h5A);
        t_unselected();
        t_selected();
        t_finish();
        do_load(16'h3C96, 8'hFF);
        t_selected();
        t_stall();
        do_load(16'h0001, 8'h00);
        send_px(8'hC8, "R7 reload first bit");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule